// File: doc/BRIEF.md
# Frame Interval Monitor

This block watches a video stream's frame cadence and flags when the time between frames drifts away from what the sensor should deliver. Each frame event is stamped with a free-running microsecond counter. The gap between two stamps is one interval sample. Samples that are implausibly long, such as a missed frame, are thrown away. The rest are summed over a window of a configured length. The window's mean is then compared with a nominal interval. If the mean misses the nominal by more than a tolerance, a one-cycle error pulse is raised. A typical fault is a decoder that loses vertical lock: its intervals drop below nominal by a fixed amount and stay there.

The frame event comes from one of two places. One is a sync pin, captured on its rising edge, its falling edge or both. The other is an end-of-frame strobe that is used when pin capture is off. After a restart the block ignores a configured number of events. The next event only sets the reference stamp, and averaging begins after that. The block restarts when it is enabled and whenever any setting changes. It always exposes the most recent mean.

Top module: `frame_interval_monitor`

## Requirements
- R1: After reset, `avgOut` is 0 and `errPulse` is low.
- R2: `capEdge` selects the event source: 2'b00 takes each cycle of `eofPulse` high as an event; 2'b01 takes rising edges of `syncIn`; 2'b10 takes falling edges; 2'b11 takes both edges. Intervals are counted in whole microseconds, where one microsecond is `CLK_PER_US` clock cycles.
- R3: After a restart, the first `cfgSkip` events are ignored. The event after them only records the reference time and yields no sample.
- R4: Once `cfgAvgNum` samples have been accepted, `avgOut` becomes the floor of their sum divided by `cfgAvgNum`. A value of 0 in `cfgAvgNum` behaves as 1. The sum and count then clear, and a new window starts.
- R5: An interval greater than `cfgTolMax` is discarded and does not count toward the window. An interval equal to `cfgTolMax` is kept. Either way, the event renews the reference time.
- R6: At each evaluation, `errPulse` is high for exactly one cycle when the absolute difference between the new mean and `cfgNominal` exceeds `cfgTolMin`. A difference equal to `cfgTolMin` gives no pulse. `errPulse` is never high outside an evaluation.
- R7: A change of `enable`, `capEdge` or any `cfg*` input while enabled restarts the monitor: the skip count reloads, the reference is dropped and the partial window is cleared. The new settings apply from then on.
- R8: While `enable` is low, events are ignored and `errPulse` stays low.
- R9: `avgOut` holds its value between evaluations, including across restarts and while the monitor is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Monitor on |
| capEdge | input | 2 | Event source and edge select |
| syncIn | input | 1 | Asynchronous frame sync pin |
| eofPulse | input | 1 | Synchronous end-of-frame strobe |
| cfgAvgNum | input | AVG_W | Samples per averaging window |
| cfgSkip | input | SKIP_W | Events ignored after a restart |
| cfgNominal | input | TS_W | Expected interval, in microseconds |
| cfgTolMin | input | TS_W | Allowed deviation of the mean, in microseconds |
| cfgTolMax | input | TS_W | Largest interval accepted as a sample |
| errPulse | output | 1 | One-cycle interval error event |
| avgOut | output | TS_W | Last evaluated mean interval, in microseconds |

## Verification
Several properties are checked on every cycle. The error pulse is always one cycle wide and only follows an evaluation. The mean changes only at an evaluation. No pulse appears while the block is disabled. A settings change always restarts the control, and no sample is taken in the cycle after a restart. The actual numbers can only be shown by the bench's scenarios, because they depend on whole event sequences. These numbers are the means, the skip and reference handling, the discard boundary, the tolerance boundary and the loss of a partial window on a restart. The bench therefore runs a reference model that tracks microsecond event times and compares its results after each window.

// File: rtl/fim_pkg.sv
`timescale 1ns/1ps
package fim_pkg;

  typedef enum logic [1:0] {
    SRC_EOF  = 2'b00,
    SRC_RISE = 2'b01,
    SRC_FALL = 2'b10,
    SRC_BOTH = 2'b11
  } srcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic takeRef;
    logic addSample;
    logic divStart;
    logic finish;
  } fimCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic evt;
    logic overMax;
    logic lastSlot;
    logic divDone;
  } fimSts_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_ARM,
    ST_ACCUM,
    ST_LOAD,
    ST_DIVIDE
  } fimState_e;

endpackage

// File: rtl/fim_timebase.sv
`timescale 1ns/1ps
module fim_timebase #(
  parameter int CLK_PER_US = 200,
  parameter int TS_W       = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] usNow
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [PRE_W-1:0] preCnt;
  logic             usTick;

  assign usTick = (preCnt == PRE_W'(CLK_PER_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
      usNow  <= '0;
    end else if (usTick) begin
      preCnt <= '0;
      usNow  <= usNow + TS_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/fim_event_src.sv
`timescale 1ns/1ps
module fim_event_src import fim_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] capEdge,
  input  logic       syncIn,
  input  logic       eofPulse,
  output logic       evt
);
  logic [SYNC_STAGES:0] syncQ;
  logic                 riseSeen, fallSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[SYNC_STAGES-1:0], syncIn};
  end

  assign riseSeen =  syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
  assign fallSeen = ~syncQ[SYNC_STAGES-1] &  syncQ[SYNC_STAGES];

  always_comb begin
    unique case (srcSel_e'(capEdge))
      SRC_EOF:  evt = eofPulse;
      SRC_RISE: evt = riseSeen;
      SRC_FALL: evt = fallSeen;
      default:  evt = riseSeen | fallSeen;
    endcase
  end
endmodule

// File: rtl/fim_datapath.sv
`timescale 1ns/1ps
module fim_datapath import fim_pkg::*; #(
  parameter int TS_W  = 20,
  parameter int AVG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fimCtl_t          ctl,
  input  logic             evtIn,
  input  logic [TS_W-1:0]  usNow,
  input  logic [AVG_W-1:0] cfgAvgNum,
  input  logic [TS_W-1:0]  cfgNominal,
  input  logic [TS_W-1:0]  cfgTolMin,
  input  logic [TS_W-1:0]  cfgTolMax,
  output fimSts_t          sts,
  output logic             errPulse,
  output logic [TS_W-1:0]  avgOut
);
  localparam int ACC_W  = TS_W + AVG_W;
  localparam int DIV_CW = $clog2(ACC_W + 1);

  logic [TS_W-1:0]   refTs, sample, avgReg, quotient, deviation;
  logic [ACC_W-1:0]  acc, dvd;
  logic [AVG_W-1:0]  cnt, effN, rem;
  logic [AVG_W:0]    remShift;
  logic [DIV_CW-1:0] divCnt;
  logic              busy, quoReady, errReg, outOfTol, fitsDivisor;

  // zero samples per window behaves as one
  assign effN      = (cfgAvgNum == '0) ? AVG_W'(1) : cfgAvgNum;
  assign sample    = usNow - refTs;
  assign remShift  = {rem, dvd[ACC_W-1]};
  assign fitsDivisor = (remShift >= {1'b0, effN});
  assign quotient  = dvd[TS_W-1:0];
  assign deviation = (quotient >= cfgNominal) ? (quotient - cfgNominal)
                                              : (cfgNominal - quotient);
  assign outOfTol  = (deviation > cfgTolMin);

  assign sts.evt      = evtIn;
  assign sts.overMax  = (sample > cfgTolMax);
  assign sts.lastSlot = (cnt == effN - AVG_W'(1));
  assign sts.divDone  = quoReady;

  // reference timestamp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           refTs <= '0;
    else if (ctl.takeRef) refTs <= usNow;
  end

  // window accumulator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (ctl.restart || ctl.divStart) begin
      acc <= '0;
      cnt <= '0;
    end else if (ctl.addSample) begin
      acc <= acc + ACC_W'(sample);
      cnt <= cnt + AVG_W'(1);
    end
  end

  // restoring divider, one quotient bit per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd      <= '0;
      rem      <= '0;
      divCnt   <= '0;
      busy     <= 1'b0;
      quoReady <= 1'b0;
    end else if (ctl.restart) begin
      busy     <= 1'b0;
      quoReady <= 1'b0;
    end else if (ctl.divStart) begin
      dvd      <= acc;
      rem      <= '0;
      divCnt   <= DIV_CW'(ACC_W);
      busy     <= 1'b1;
      quoReady <= 1'b0;
    end else if (busy) begin
      if (fitsDivisor) begin
        rem <= AVG_W'(remShift - {1'b0, effN});
        dvd <= {dvd[ACC_W-2:0], 1'b1};
      end else begin
        rem <= remShift[AVG_W-1:0];
        dvd <= {dvd[ACC_W-2:0], 1'b0};
      end
      divCnt <= divCnt - DIV_CW'(1);
      if (divCnt == DIV_CW'(1)) begin
        busy     <= 1'b0;
        quoReady <= 1'b1;
      end
    end else begin
      quoReady <= 1'b0;
    end
  end

  // result and error event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avgReg <= '0;
      errReg <= 1'b0;
    end else begin
      errReg <= ctl.finish & outOfTol;
      if (ctl.finish) avgReg <= quotient;
    end
  end

  assign errPulse = errReg;
  assign avgOut   = avgReg;
endmodule

// File: rtl/fim_control.sv
`timescale 1ns/1ps
module fim_control import fim_pkg::*; #(
  parameter int SKIP_W = 4,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CFG_W-1:0]  cfgVec,
  input  logic [SKIP_W-1:0] cfgSkip,
  input  fimSts_t           sts,
  output fimCtl_t           ctl
);
  fimState_e         state, nextState;
  logic [SKIP_W-1:0] skipLeft, nextSkip;
  logic [CFG_W-1:0]  cfgPrev;
  logic              restartNow;
  fimState_e         startState;

  // shadow of the settings from the previous cycle
  always_ff @(posedge clk) cfgPrev <= cfgVec;

  assign restartNow = !enable || (cfgVec != cfgPrev);
  assign startState = (cfgSkip == '0) ? ST_ARM : ST_SKIP;

  always_comb begin
    ctl       = '0;
    nextState = state;
    nextSkip  = skipLeft;
    if (restartNow || state == ST_IDLE) begin
      ctl.restart = 1'b1;
      nextSkip    = cfgSkip;
      nextState   = enable ? startState : ST_IDLE;
    end else begin
      unique case (state)
        ST_SKIP: if (sts.evt) begin
          nextSkip = skipLeft - SKIP_W'(1);
          if (skipLeft == SKIP_W'(1)) nextState = ST_ARM;
        end
        ST_ARM: if (sts.evt) begin
          ctl.takeRef = 1'b1;
          nextState   = ST_ACCUM;
        end
        ST_ACCUM: if (sts.evt) begin
          ctl.takeRef = 1'b1;
          if (!sts.overMax) begin
            ctl.addSample = 1'b1;
            if (sts.lastSlot) nextState = ST_LOAD;
          end
        end
        ST_LOAD: begin
          ctl.takeRef  = sts.evt;
          ctl.divStart = 1'b1;
          nextState    = ST_DIVIDE;
        end
        ST_DIVIDE: begin
          ctl.takeRef = sts.evt;
          if (sts.divDone) begin
            ctl.finish = 1'b1;
            nextState  = ST_ACCUM;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      skipLeft <= '0;
    end else begin
      state    <= nextState;
      skipLeft <= nextSkip;
    end
  end
endmodule

// File: rtl/frame_interval_monitor.sv
`timescale 1ns/1ps
module frame_interval_monitor import fim_pkg::*; #(
  parameter int CLK_PER_US  = 200,
  parameter int TS_W        = 20,
  parameter int AVG_W       = 4,
  parameter int SKIP_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        capEdge,
  input  logic              syncIn,
  input  logic              eofPulse,
  input  logic [AVG_W-1:0]  cfgAvgNum,
  input  logic [SKIP_W-1:0] cfgSkip,
  input  logic [TS_W-1:0]   cfgNominal,
  input  logic [TS_W-1:0]   cfgTolMin,
  input  logic [TS_W-1:0]   cfgTolMax,
  output logic              errPulse,
  output logic [TS_W-1:0]   avgOut
);
  localparam int CFG_W = 3 + AVG_W + SKIP_W + 3 * TS_W;

  logic [TS_W-1:0]  usNow;
  logic             evt;
  logic [CFG_W-1:0] cfgVec;
  fimCtl_t          ctlBus;
  fimSts_t          stsBus;

  assign cfgVec = {enable, capEdge, cfgAvgNum, cfgSkip, cfgNominal, cfgTolMin, cfgTolMax};

  fim_timebase #(.CLK_PER_US(CLK_PER_US), .TS_W(TS_W)) u_timebase (
    .clk(clk), .rst_n(rst_n), .usNow(usNow)
  );

  fim_event_src #(.SYNC_STAGES(SYNC_STAGES)) u_evtsrc (
    .clk(clk), .rst_n(rst_n), .capEdge(capEdge),
    .syncIn(syncIn), .eofPulse(eofPulse), .evt(evt)
  );

  fim_control #(.SKIP_W(SKIP_W), .CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfgVec(cfgVec),
    .cfgSkip(cfgSkip), .sts(stsBus), .ctl(ctlBus)
  );

  fim_datapath #(.TS_W(TS_W), .AVG_W(AVG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctlBus), .evtIn(evt), .usNow(usNow),
    .cfgAvgNum(cfgAvgNum), .cfgNominal(cfgNominal), .cfgTolMin(cfgTolMin),
    .cfgTolMax(cfgTolMax), .sts(stsBus), .errPulse(errPulse), .avgOut(avgOut)
  );
endmodule

// File: rtl/frame_interval_monitor_sva.sv
`timescale 1ns/1ps
module frame_interval_monitor_sva import fim_pkg::*; #(
  parameter int TS_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic [1:0]      capEdge,
  input logic [TS_W-1:0] cfgNominal,
  input logic [TS_W-1:0] cfgTolMin,
  input logic [TS_W-1:0] cfgTolMax,
  input logic            errPulse,
  input logic [TS_W-1:0] avgOut,
  input fimCtl_t         ctlBus
);
  p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    errPulse |=> !errPulse);

  p_err_after_eval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    errPulse |-> $past(ctlBus.finish));

  p_avg_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(avgOut) |-> $past(ctlBus.finish));

  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !errPulse);

  p_restart_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (!$stable(cfgNominal) || !$stable(cfgTolMin) ||
                !$stable(cfgTolMax) || !$stable(capEdge))) |-> ctlBus.restart);

  p_no_sample_after_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctlBus.restart |=> !ctlBus.addSample);

  p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctlBus.restart, ctlBus.addSample, ctlBus.divStart, ctlBus.finish}));
endmodule

bind frame_interval_monitor frame_interval_monitor_sva #(.TS_W(TS_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .enable(enable), .capEdge(capEdge),
  .cfgNominal(cfgNominal), .cfgTolMin(cfgTolMin), .cfgTolMax(cfgTolMax),
  .errPulse(errPulse), .avgOut(avgOut), .ctlBus(ctlBus)
);

// File: tb/frame_interval_monitor_test.sv
`timescale 1ns/1ps
module frame_interval_monitor_test;
  localparam int CPU    = 4;
  localparam int TS_W   = 16;
  localparam int AVG_W  = 4;
  localparam int SKIP_W = 3;

  logic              clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0]        capEdge = 2'b00;
  logic              syncIn = 1'b0, eofPulse = 1'b0;
  logic [AVG_W-1:0]  cfgAvgNum = '0;
  logic [SKIP_W-1:0] cfgSkip = '0;
  logic [TS_W-1:0]   cfgNominal = '0, cfgTolMin = '0, cfgTolMax = '0;
  logic              errPulse;
  logic [TS_W-1:0]   avgOut;

  frame_interval_monitor #(.CLK_PER_US(CPU), .TS_W(TS_W), .AVG_W(AVG_W), .SKIP_W(SKIP_W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .capEdge(capEdge), .syncIn(syncIn),
    .eofPulse(eofPulse), .cfgAvgNum(cfgAvgNum), .cfgSkip(cfgSkip), .cfgNominal(cfgNominal),
    .cfgTolMin(cfgTolMin), .cfgTolMax(cfgTolMax), .errPulse(errPulse), .avgOut(avgOut)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, errSeen = 0, errBase = 0, windowsDone = 0;
  int benchUs = 0;
  // reference model state
  int mSkip = 0, mLast = 0, mSum = 0, mCnt = 0;
  bit mArmed = 0;
  bit pend = 0;
  int pendAvg = 0, pendErr = 0;
  string curTag = "R4";

  always @(posedge clk) if (rst_n && errPulse) errSeen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int effN();
    return (cfgAvgNum == '0) ? 1 : int'(cfgAvgNum);
  endfunction

  task automatic modelRestart();
    mSkip = int'(cfgSkip); mArmed = 0; mSum = 0; mCnt = 0; pend = 0;
  endtask

  task automatic feed();
    int iv, dev;
    if (!enable) return;
    if (mSkip > 0) mSkip--;
    else if (!mArmed) begin mArmed = 1; mLast = benchUs; end
    else begin
      iv = benchUs - mLast; mLast = benchUs;
      if (iv <= int'(cfgTolMax)) begin
        mSum += iv; mCnt++;
        if (mCnt == effN()) begin
          pendAvg = mSum / mCnt;
          dev = (pendAvg > int'(cfgNominal)) ? pendAvg - int'(cfgNominal) : int'(cfgNominal) - pendAvg;
          pendErr = (dev > int'(cfgTolMin)) ? 1 : 0;
          pend = 1; mSum = 0; mCnt = 0;
        end
      end
    end
  endtask

  task automatic advance(input int us);
    for (int i = 0; i < us; i++) begin
      repeat (CPU) begin @(negedge clk); eofPulse = 1'b0; end
      benchUs++;
      if (pend && i == 14) begin
        check(curTag, int'(avgOut), pendAvg);
        check("R6", errSeen - errBase, pendErr);
        errBase = errSeen; pend = 0; windowsDone++;
      end
    end
  endtask

  task automatic eofEv(input int us);
    advance(us); eofPulse = 1'b1; feed();
  endtask

  task automatic togg(input int us);
    advance(us); syncIn = ~syncIn;
    if (capEdge == 2'b11 || (capEdge == 2'b01 && syncIn) || (capEdge == 2'b10 && !syncIn)) feed();
  endtask

  task automatic setCfg(input int src, input int n, input int sk, input int nom, input int tmin, input int tmax);
    advance(20);
    capEdge = 2'(src); cfgAvgNum = AVG_W'(n); cfgSkip = SKIP_W'(sk);
    cfgNominal = TS_W'(nom); cfgTolMin = TS_W'(tmin); cfgTolMax = TS_W'(tmax);
    modelRestart();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, held, base;
    void'($urandom(32'd4242));
    enable = 1'b1; cfgAvgNum = 4'd4; cfgSkip = 3'd2; cfgNominal = 16'd160;
    cfgTolMin = 16'd20; cfgTolMax = 16'd400;
    repeat (10) @(negedge clk);
    check("R1", int'(avgOut), 0);
    check("R1", int'(errPulse), 0);
    rst_n = 1'b1;
    modelRestart();

    // R2/R4: end-of-frame source, random intervals near nominal
    curTag = "R4";
    for (int i = 0; i < 11; i++) eofEv(140 + int'($urandom_range(40)));
    // R6: intervals pinned 60 us short
    curTag = "R6";
    for (int i = 0; i < 4; i++) eofEv(100);
    // R6 boundary: deviation equal to tolerance, then one above
    for (int i = 0; i < 4; i++) eofEv(140);
    for (int i = 0; i < 4; i++) eofEv(139);
    for (int i = 0; i < 4; i++) eofEv(180);
    advance(20);

    // R5: discard above limit, keep equal
    setCfg(0, 2, 2, 160, 20, 250);
    curTag = "R5";
    for (int i = 0; i < 3; i++) eofEv(100);
    eofEv(150); eofEv(251); eofEv(250);

    // R4: zero window length acts as one
    setCfg(0, 0, 2, 160, 20, 400);
    curTag = "R4";
    for (int i = 0; i < 3; i++) eofEv(90);
    eofEv(120); eofEv(165);

    // R2: pin sources, rising, falling, both
    curTag = "R2";
    setCfg(1, 2, 0, 150, 5, 400);
    for (int i = 0; i < 8; i++) togg((i % 2) ? 90 : 60);
    setCfg(2, 2, 0, 150, 5, 400);
    for (int i = 0; i < 8; i++) togg((i % 2) ? 70 : 110);
    setCfg(3, 2, 0, 150, 5, 400);
    for (int i = 0; i < 6; i++) togg((i % 2) ? 90 : 60);

    // R3: skipped events then reference only
    curTag = "R3";
    setCfg(0, 1, 3, 150, 0, 400);
    eofEv(70); eofEv(80); eofEv(90); eofEv(100); eofEv(150);

    // R7: settings change mid-window drops partial sum
    curTag = "R7";
    setCfg(0, 4, 0, 160, 20, 400);
    eofEv(100); eofEv(100); eofEv(100);
    advance(20);
    cfgTolMin = 16'd30; modelRestart();
    for (int i = 0; i < 5; i++) eofEv(160);
    advance(20);

    // R8/R9: disabled monitor ignores events and keeps its mean
    held = int'(avgOut); base = errSeen;
    enable = 1'b0; cfgAvgNum = 4'd1; cfgSkip = 3'd0; cfgNominal = 16'd500;
    for (int i = 0; i < 4; i++) eofEv(60);
    advance(20);
    check("R8", errSeen - base, 0);
    check("R9", int'(avgOut), held);
    enable = 1'b1; modelRestart();

    // random phase
    curTag = "R4";
    for (int w = 0; w < 8; w++) begin
      setCfg(int'($urandom_range(3)), 1 + int'($urandom_range(3)), int'($urandom_range(2)),
             100 + int'($urandom_range(100)), int'($urandom_range(40)), 120 + int'($urandom_range(180)));
      base = windowsDone;
      for (int e = 0; e < 24 && windowsDone == base; e++) begin
        v = 50 + int'($urandom_range(100));
        if (capEdge == 2'b00) eofEv(v); else togg(v);
      end
      advance(20);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule